// File: doc/BRIEF.md
# Circular Address Generator Pair

This block produces operand addresses for circular buffers. It holds two independent generator units, so two operand addresses can be issued in the same clock cycle. Each unit owns four register sets. Every set has four 32-bit registers: a current pointer, a step, a window size and a window start.

On a request, the unit issues the current pointer of the chosen set as the address. It then moves that pointer by a step. The step is taken from whichever set the request's step-select names. After the move, the pointer is folded back so that it stays inside the window that begins at the window start and covers window-size words. A window size of zero turns folding off, and the pointer then advances linearly.

Software or a sequencer loads the registers through a per-unit write port. Loading the window start also places the pointer at the start of the buffer.

Top module: `circ_agen_dual`

## Requirements
- R1: After a synchronous active-low reset, every register of every set in both units is zero and `addr_vld` is low. A request issued right after reset returns address 0.
- R2: A request sampled at a clock edge shows the chosen set's pointer (its value before that edge) on `addr`, with `addr_vld` high, just after that edge. A cycle with no request drives `addr_vld` low and leaves `addr` unchanged.
- R3: After a request, the chosen set's pointer is updated to pointer plus step. The step is read from the set named by `req_msel`, is treated as a signed two's-complement value, and a step of zero leaves the pointer in place.
- R4: When the chosen set's window size is zero, the new pointer is pointer plus step modulo 2^32, with no bounds check.
- R5: For a non-negative step with a non-zero window size, if pointer plus step (computed without truncation) is at or above window start plus window size, the window size is subtracted.
- R6: For a negative step with a non-zero window size, if pointer plus step falls below the window start, the window size is added.
- R7: A write stores `wr_data` into one register of set `wr_set`, effective from the next cycle. `wr_field` selects the register: 0 pointer, 1 step, 2 window size, 3 window start. Writing the window start also loads the same value into that set's pointer.
- R8: When a write and a request name the same set in the same cycle, the write wins. The address is still issued from the old pointer, but the pointer is not stepped.
- R9: The two units are fully independent. Each can write and request in the same cycle with its own set, step and window.
- R10: A request changes only the pointer of the set it names. The other sets' pointers are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | NGEN | Register write strobe, one bit per unit |
| wr_set | input | NGEN*SW | Set number of each unit's write |
| wr_field | input | NGEN*2 | Register select of each unit's write (0 pointer, 1 step, 2 size, 3 start) |
| wr_data | input | NGEN*AW | Write data of each unit |
| req_vld | input | NGEN | Address request, one bit per unit |
| req_set | input | NGEN*SW | Set whose pointer is issued and stepped |
| req_msel | input | NGEN*SW | Set whose step register is applied |
| addr | output | NGEN*AW | Issued address of each unit |
| addr_vld | output | NGEN | Issued address valid, one bit per unit |

## Verification
The bench sweeps every window size from 0 to 5 against every step from minus to plus that size. Each combination walks the pointer for more than two full laps, so wraps in both directions, exact landings on the window edges and zero steps are all covered. One unit runs at a low window start and the other uses the negated step near the top of the address space. This separates correct wide comparisons from truncated ones, and the zero-size runs there show the modulo-2^32 linear advance. Directed cycles check write/request collisions on one set, step selection from a different set, the pointer load on a window-start write, and whether untouched sets keep their pointers.

// File: rtl/circ_agen_pkg.sv
// Shared definitions for the circular address generator.
package circ_agen_pkg;

    // Register select codes of the write port
    typedef enum logic [1:0] {
        FLD_PTR   = 2'd0,
        FLD_STEP  = 2'd1,
        FLD_SIZE  = 2'd2,
        FLD_START = 2'd3
    } fld_e;

endpackage

// File: rtl/circ_wrap_calc.sv
// Next-pointer arithmetic for one circular buffer.
// Adds a signed step to the pointer, then folds the result back into
// [start, start+size) by one size, and only when size is non-zero.
// Assumes |step| <= size for folding to land inside the window; larger
// steps give the plain one-fold result. clk/rst_n serve only the checks.
module circ_wrap_calc #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ptr,
    input  logic [AW-1:0] step,
    input  logic [AW-1:0] size,
    input  logic [AW-1:0] start,
    output logic [AW-1:0] nxt
);
    localparam int EW = AW + 2;

    logic [EW-1:0] sum_e;
    logic [EW-1:0] lim_e;
    logic [EW-1:0] start_e;

    // Untruncated sum and window end, then a single fold in the step's direction
    always_comb begin
        start_e = {2'b00, start};
        lim_e   = start_e + {2'b00, size};
        sum_e   = {2'b00, ptr} + {{2{step[AW-1]}}, step};
        nxt     = sum_e[AW-1:0];
        if (size != '0) begin
            if (!step[AW-1]) begin
                if ($signed(sum_e) >= $signed(lim_e)) nxt = sum_e[AW-1:0] - size;
            end else if ($signed(sum_e) < $signed(start_e)) begin
                nxt = sum_e[AW-1:0] + size;
            end
        end
    end

    // Check-side view: window bounds and step magnitude
    logic [AW:0]   win_end;
    logic [AW-1:0] step_mag;
    logic          pre_ok;
    logic          post_in;
    assign win_end  = {1'b0, start} + {1'b0, size};
    assign step_mag = step[AW-1] ? (~step + 1'b1) : step;
    assign pre_ok   = (size != '0) && !win_end[AW] && (ptr >= start) &&
                      ({1'b0, ptr} < win_end) && (step_mag <= size);
    assign post_in  = (nxt >= start) && ({1'b0, nxt} < win_end);

    // R5/R6: an in-window pointer with a legal step stays in the window
    a_r5_r6_stays_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        pre_ok |-> post_in);

    // R4: a zero size gives the plain modular sum
    a_r4_linear_zero_size: assert property (@(posedge clk) disable iff (!rst_n)
        (size == '0) |-> (nxt == AW'(ptr + step)));

endmodule

// File: rtl/circ_agen.sv
// One circular address generator unit with NSETS register sets.
// A request issues the chosen set's pointer on a registered output and
// post-steps that pointer. A same-set write in the same cycle suppresses
// the step. Assumes set numbers are below NSETS.
module circ_agen
    import circ_agen_pkg::*;
#(
    parameter int AW    = 32,
    parameter int NSETS = 4,
    localparam int SW   = (NSETS > 1) ? $clog2(NSETS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_set,
    input  logic [1:0]    wr_field,
    input  logic [AW-1:0] wr_data,
    input  logic          req_vld,
    input  logic [SW-1:0] req_set,
    input  logic [SW-1:0] req_msel,
    output logic [AW-1:0] addr,
    output logic          addr_vld
);
    logic [AW-1:0] ptr_v   [NSETS];
    logic [AW-1:0] step_v  [NSETS];
    logic [AW-1:0] size_v  [NSETS];
    logic [AW-1:0] start_v [NSETS];
    logic [AW-1:0] nxt_ptr;

    circ_wrap_calc #(.AW(AW)) u_wrap (
        .clk   (clk),
        .rst_n (rst_n),
        .ptr   (ptr_v[req_set]),
        .step  (step_v[req_msel]),
        .size  (size_v[req_set]),
        .start (start_v[req_set]),
        .nxt   (nxt_ptr)
    );

    for (genvar s = 0; s < NSETS; s++) begin : g_set
        logic [AW-1:0] ptr_r, step_r, size_r, start_r;
        logic          hit_w, step_w;
        assign hit_w  = wr_en && (wr_set == SW'(s));
        assign step_w = req_vld && (req_set == SW'(s)) && !hit_w;

        // Register write (with priority) or post-step of this set's pointer
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ptr_r   <= '0;
                step_r  <= '0;
                size_r  <= '0;
                start_r <= '0;
            end else if (hit_w) begin
                case (wr_field)
                    FLD_PTR:   ptr_r  <= wr_data;
                    FLD_STEP:  step_r <= wr_data;
                    FLD_SIZE:  size_r <= wr_data;
                    default: begin
                        start_r <= wr_data;
                        ptr_r   <= wr_data;
                    end
                endcase
            end else if (step_w) begin
                ptr_r <= nxt_ptr;
            end
        end

        assign ptr_v[s]   = ptr_r;
        assign step_v[s]  = step_r;
        assign size_v[s]  = size_r;
        assign start_v[s] = start_r;
    end

    // Registered address output; holds its value while idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr     <= '0;
            addr_vld <= 1'b0;
        end else begin
            addr_vld <= req_vld;
            if (req_vld) addr <= ptr_v[req_set];
        end
    end

    // R2: a request yields a valid address equal to the old pointer
    a_r2_issue_old_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> (addr_vld && (addr == $past(ptr_v[req_set]))));

    // R2: an idle cycle drops valid and holds the address
    a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> (!addr_vld && $stable(addr)));

    // R8: a same-set step write during a request leaves the pointer unstepped
    a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && wr_en && (wr_set == req_set) && (wr_field == FLD_STEP))
        |=> (ptr_v[$past(req_set)] == $past(ptr_v[req_set])));

    // R7: a window-start write also loads the pointer
    a_r7_start_loads_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_field == FLD_START))
        |=> ((ptr_v[$past(wr_set)] == $past(wr_data)) &&
             (start_v[$past(wr_set)] == $past(wr_data))));

endmodule

// File: rtl/circ_agen_dual.sv
// Two independent circular address generator units side by side, so two
// operand addresses can be issued per cycle. Ports are flattened per unit,
// with unit g in slice g of each vector.
module circ_agen_dual #(
    parameter int AW    = 32,
    parameter int NSETS = 4,
    parameter int NGEN  = 2,
    localparam int SW   = (NSETS > 1) ? $clog2(NSETS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NGEN-1:0]    wr_en,
    input  logic [NGEN*SW-1:0] wr_set,
    input  logic [NGEN*2-1:0]  wr_field,
    input  logic [NGEN*AW-1:0] wr_data,
    input  logic [NGEN-1:0]    req_vld,
    input  logic [NGEN*SW-1:0] req_set,
    input  logic [NGEN*SW-1:0] req_msel,
    output logic [NGEN*AW-1:0] addr,
    output logic [NGEN-1:0]    addr_vld
);
    for (genvar g = 0; g < NGEN; g++) begin : g_unit
        circ_agen #(.AW(AW), .NSETS(NSETS)) u_agen (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_en[g]),
            .wr_set   (wr_set[g*SW +: SW]),
            .wr_field (wr_field[g*2 +: 2]),
            .wr_data  (wr_data[g*AW +: AW]),
            .req_vld  (req_vld[g]),
            .req_set  (req_set[g*SW +: SW]),
            .req_msel (req_msel[g*SW +: SW]),
            .addr     (addr[g*AW +: AW]),
            .addr_vld (addr_vld[g])
        );
    end

endmodule

// File: tb/sim_circ_agen_dual.sv
`timescale 1ns/1ps
module sim_circ_agen_dual;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  wr_en = '0;
    logic [3:0]  wr_set = '0;
    logic [3:0]  wr_field = '0;
    logic [63:0] wr_data = '0;
    logic [1:0]  req_vld = '0;
    logic [3:0]  req_set = '0;
    logic [3:0]  req_msel = '0;
    logic [63:0] addr;
    logic [1:0]  addr_vld;

    int n_chk = 0;
    int n_fail = 0;

    logic [31:0] m_ptr   [2][4];
    logic [31:0] m_step  [2][4];
    logic [31:0] m_size  [2][4];
    logic [31:0] m_start [2][4];
    logic [31:0] e_addr  [2];
    logic        e_vld   [2];

    always #4 clk = ~clk;

    circ_agen_dual u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_set(wr_set),
        .wr_field(wr_field), .wr_data(wr_data), .req_vld(req_vld),
        .req_set(req_set), .req_msel(req_msel), .addr(addr), .addr_vld(addr_vld)
    );

    // Next pointer from the requirements (R3..R6), in wide integer arithmetic
    function automatic logic [31:0] ref_next(logic [31:0] p, logic [31:0] st,
                                             logic [31:0] sz, logic [31:0] b);
        longint s;
        s = longint'(p) + longint'($signed(st));
        if (sz != 0) begin
            if (!st[31] && s >= longint'(b) + longint'(sz)) s = s - longint'(sz);
            else if (st[31] && s < longint'(b)) s = s + longint'(sz);
        end
        return s[31:0];
    endfunction

    task automatic wr(int g, int s, int f, logic [31:0] d);
        wr_en[g] = 1'b1;
        wr_set[g*2 +: 2] = 2'(s);
        wr_field[g*2 +: 2] = 2'(f);
        wr_data[g*32 +: 32] = d;
    endtask

    task automatic rq(int g, int s, int ms);
        req_vld[g] = 1'b1;
        req_set[g*2 +: 2] = 2'(s);
        req_msel[g*2 +: 2] = 2'(ms);
    endtask

    task automatic chk(string tag, int g, logic [32:0] got, logic [32:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s unit%0d: got vld=%0b addr=%h, expected vld=%0b addr=%h",
                     tag, g, got[32], got[31:0], exp[32], exp[31:0]);
        end
    endtask

    // One clock: update the model with the driven inputs, then compare both units
    task automatic tick(string t0, string t1);
        @(posedge clk);
        for (int g = 0; g < 2; g++) begin
            int rs, ms, ws;
            logic [31:0] nx;
            rs = int'(req_set[g*2 +: 2]);
            ms = int'(req_msel[g*2 +: 2]);
            ws = int'(wr_set[g*2 +: 2]);
            e_vld[g] = req_vld[g];
            nx = ref_next(m_ptr[g][rs], m_step[g][ms], m_size[g][rs], m_start[g][rs]);
            if (req_vld[g]) begin
                e_addr[g] = m_ptr[g][rs];
                if (!(wr_en[g] && ws == rs)) m_ptr[g][rs] = nx;
            end
            if (wr_en[g]) begin
                case (int'(wr_field[g*2 +: 2]))
                    0: m_ptr[g][ws] = wr_data[g*32 +: 32];
                    1: m_step[g][ws] = wr_data[g*32 +: 32];
                    2: m_size[g][ws] = wr_data[g*32 +: 32];
                    default: begin
                        m_start[g][ws] = wr_data[g*32 +: 32];
                        m_ptr[g][ws] = wr_data[g*32 +: 32];
                    end
                endcase
            end
        end
        #1;
        chk(t0, 0, {addr_vld[0], addr[31:0]},  {e_vld[0], e_addr[0]});
        chk(t1, 1, {addr_vld[1], addr[63:32]}, {e_vld[1], e_addr[1]});
        wr_en = '0;
        req_vld = '0;
    endtask

    function automatic string tag_of(int sz, int st);
        if (sz == 0) return "R4";
        if (st > 0) return "R5";
        if (st < 0) return "R6";
        return "R3";
    endfunction

    initial begin
        for (int g = 0; g < 2; g++) begin
            e_addr[g] = '0;
            e_vld[g] = 1'b0;
            for (int s = 0; s < 4; s++) begin
                m_ptr[g][s] = '0; m_step[g][s] = '0;
                m_size[g][s] = '0; m_start[g][s] = '0;
            end
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state, then a request returns zero
        tick("R1", "R1");
        rq(0, 3, 0); rq(1, 3, 2); tick("R1", "R1");
        tick("R2", "R2");

        // R7: load pointer and step fields directly
        wr(0, 0, 0, 32'h40); wr(1, 0, 1, 32'hFFFF_FFFF); tick("R7", "R7");
        wr(0, 0, 1, 32'h3);  wr(1, 0, 0, 32'h20);        tick("R7", "R7");
        rq(0, 0, 0); rq(1, 0, 0); tick("R7", "R7");   // 0x40 / 0x20
        rq(0, 0, 0); rq(1, 0, 0); tick("R3", "R3");   // 0x43 / 0x1F
        tick("R2", "R2");

        // R8: same-set step write collides with a request
        rq(0, 0, 0); wr(0, 0, 1, 32'h5); tick("R8", "R9");  // issues 0x46, no step
        rq(0, 0, 0); tick("R8", "R2");                      // 0x46 again
        rq(0, 0, 0); tick("R8", "R2");                      // 0x4B
        // R8: window-start write collides with a request
        rq(1, 0, 0); wr(1, 0, 3, 32'h200); tick("R2", "R8");
        rq(1, 0, 0); tick("R2", "R8");                      // 0x200

        // R10: set 1 still at zero after stepping set 0; step taken from set 0
        rq(0, 1, 0); rq(1, 2, 0); tick("R10", "R10");
        rq(0, 1, 0); rq(1, 3, 0); tick("R10", "R10");       // unit0 0x5

        // R9: same set number in both units, different results
        rq(0, 0, 0); rq(1, 0, 0); tick("R9", "R9");

        // Sweep: size 0..5 against every step -size..size, more than two laps each
        for (int sz = 0; sz <= 5; sz++) begin
            int span;
            span = (sz == 0) ? 3 : sz;
            for (int st = -span; st <= span; st++) begin
                wr(0, 2, 2, 32'(sz)); wr(1, 2, 2, 32'(sz)); tick("R7", "R7");
                wr(0, 1, 1, 32'(st)); wr(1, 1, 1, 32'(-st)); tick("R7", "R7");
                wr(0, 2, 3, 32'd100); wr(1, 2, 3, 32'hFFFF_FFFD); tick("R7", "R7");
                for (int k = 0; k < 2 * sz + 4; k++) begin
                    rq(0, 2, 1); rq(1, 2, 1);
                    tick(tag_of(sz, st), tag_of(sz, -st));
                end
            end
        end

        // R10: set 3 pointers untouched by the sweep
        rq(0, 3, 0); rq(1, 3, 0); tick("R10", "R10");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(8 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule